// File: doc/BRIEF.md
# Age-Based Cache Set Replacement

This block keeps the tag, valid and age state of a small set-associative last-level cache and decides where each new line goes. Every access strobe carries a byte address. The block splits the address into a line offset, a set index and a tag, and looks the tag up in the addressed set. One clock later it reports whether the access hit, which way hit, or which way was chosen to receive the line on a miss. The new tag is installed in that way on the same edge.

Replacement works with a two-bit age per way rather than recency ordering. A newly filled line starts old: at age 3, or at age 2 when the insertion-mode input asks for it. Each hit makes the line one step younger, down to a floor of 0. On a miss, any empty way is used first. Otherwise the search takes the first way, in way order, that is at the oldest possible age. If no way is that old, it takes the first way holding the largest age present in the set.

Top module: `llc_age_replacer`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `acc_valid` high, and low after a cycle without it. The other response outputs are valid whenever `rsp_valid` is high.
- R2: The set index is `acc_addr[OFF_W +: SET_W]` and the tag is the `TAG_W` bits directly above it. With the defaults this is bits 6..3 for the set and bits 14..7 for the tag. Bits 2..0 select a byte within the line and do not affect the lookup.
- R3: An access whose tag matches a valid way of its set is a hit, and `rsp_hit_way` gives that way. A second access to the same line always hits in the way the first access reported.
- R4: On a miss, if any way of the set is empty, the lowest-numbered empty way is filled.
- R5: After reset, every way of every set is empty and `rsp_valid` and `rsp_hit` are low.
- R6: A filled line gets age 3 when `acc_ins_mode` is 0 and age 2 when it is 1.
- R7: A hit lowers the age of the hit way by one, and an age of 0 stays at 0.
- R8: On a miss in a full set, the victim is the lowest-numbered way with age 3.
- R9: On a miss in a full set with no way at age 3, the victim is the lowest-numbered way holding the largest age in the set.
- R10: An access changes the age of no way other than the one it hits or fills. A cycle without `acc_valid` changes no state.
- R11: On a hit `rsp_victim_way` reads 0, and on a miss `rsp_hit_way` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W (15) | Byte address of the access |
| acc_ins_mode | input | 1 | Fill age select: 0 gives age 3, 1 gives age 2 |
| rsp_valid | output | 1 | Response valid, one cycle after the strobe |
| rsp_hit | output | 1 | Access hit a resident line |
| rsp_hit_way | output | WAY_W (2) | Way that hit, 0 on a miss |
| rsp_victim_way | output | WAY_W (2) | Way filled on a miss, 0 on a hit |

## Verification
In one cycle the block can both commit the state change of one access and look up the next access. Back-to-back strobes to the same set make this happen, and so do repeated strobes to the same line. The second lookup must see the age decrement or the fill from the first. The bench drives bursts with the strobe held high into a single set. A behavioural model updates its arrays at every edge and compares all responses on every clock, and a checker requires every repeated line to hit in the way that was reported for it.

// File: rtl/llc_age_pkg.sv
package llc_age_pkg;

  // Selects the age given to a newly installed line.
  typedef enum logic {
    INS_OLDEST = 1'b0,
    INS_NEAR   = 1'b1
  } ins_mode_e;

  // How an access resolved inside its set.
  typedef enum logic [1:0] {
    RES_HIT   = 2'd0,
    RES_FREE  = 2'd1,
    RES_EVICT = 2'd2
  } resolve_e;

endpackage

// File: rtl/llc_age_store.sv
module llc_age_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int AGE_W = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0]             rd_valid,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  output logic [WAYS-1:0][AGE_W-1:0]  rd_age,
  input  logic                        wr_en,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic                        wr_fill,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [AGE_W-1:0]            wr_age
);

  localparam logic [AGE_W-1:0] AGE_RST = '1;

  logic [SETS-1:0][WAYS-1:0]             val_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]  age_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic ent_en;
      logic tag_en;

      always_comb begin
        ent_en = wr_en && (wr_set == SET_W'(s)) && (wr_way == WAY_W'(w));
        tag_en = ent_en && wr_fill;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q[s][w] <= 1'b0;
          age_q[s][w] <= AGE_RST;
        end else if (ent_en) begin
          val_q[s][w] <= val_q[s][w] | wr_fill;
          age_q[s][w] <= wr_age;
        end
      end

      always_ff @(posedge clk) begin
        if (tag_en) begin
          tag_q[s][w] <= wr_tag;
        end
      end
    end
  end

  always_comb begin
    rd_valid = val_q[rd_set];
    rd_tag   = tag_q[rd_set];
    rd_age   = age_q[rd_set];
  end

endmodule

// File: rtl/llc_age_match.sv
module llc_age_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             row_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  row_tag,
  input  logic [TAG_W-1:0]            look_tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic                        free_any,
  output logic [WAY_W-1:0]            free_way
);

  logic [WAYS-1:0] match_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_vec[w] = row_valid[w] && (row_tag[w] == look_tag);
  end

  // Descending scans so the lowest-numbered candidate is the one left standing.
  always_comb begin
    hit      = |match_vec;
    free_any = ~&row_valid;
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_vec[w]) begin
        hit_way = WAY_W'(w);
      end
      if (!row_valid[w]) begin
        free_way = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/llc_age_victim.sv
module llc_age_victim #(
  parameter int WAYS  = 4,
  parameter int AGE_W = 2,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][AGE_W-1:0]  row_age,
  output logic                        top_found,
  output logic [WAY_W-1:0]            victim_way
);

  localparam logic [AGE_W-1:0] AGE_TOP = '1;

  logic [WAY_W-1:0] top_way;
  logic [WAY_W-1:0] best_way;
  logic [AGE_W-1:0] best_age;

  always_comb begin
    top_found = 1'b0;
    top_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (row_age[w] == AGE_TOP) begin
        top_found = 1'b1;
        top_way   = WAY_W'(w);
      end
    end
  end

  // Strict comparison keeps the earliest way among equal ages.
  always_comb begin
    best_age = row_age[0];
    best_way = '0;
    for (int w = 1; w < WAYS; w++) begin
      if (row_age[w] > best_age) begin
        best_age = row_age[w];
        best_way = WAY_W'(w);
      end
    end
  end

  assign victim_way = top_found ? top_way : best_way;

endmodule

// File: rtl/llc_age_replacer.sv
module llc_age_replacer
  import llc_age_pkg::*;
#(
  parameter int OFF_W = 3,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int AGE_W = 2,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int ADDR_W = OFF_W + SET_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_ins_mode,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_hit_way,
  output logic [WAY_W-1:0]  rsp_victim_way
);

  localparam logic [AGE_W-1:0] AGE_TOP  = '1;
  localparam logic [AGE_W-1:0] AGE_NEAR = AGE_TOP - AGE_W'(1);

  logic [SET_W-1:0] acc_set;
  logic [TAG_W-1:0] acc_tag;
  logic             off_unused;

  assign acc_set    = acc_addr[OFF_W +: SET_W];
  assign acc_tag    = acc_addr[OFF_W + SET_W +: TAG_W];
  assign off_unused = ^acc_addr[OFF_W-1:0];

  logic [WAYS-1:0]             row_valid;
  logic [WAYS-1:0][TAG_W-1:0]  row_tag;
  logic [WAYS-1:0][AGE_W-1:0]  row_age;

  logic             lk_hit;
  logic [WAY_W-1:0] lk_hit_way;
  logic             lk_free_any;
  logic [WAY_W-1:0] lk_free_way;
  logic             lk_top_found;
  logic [WAY_W-1:0] lk_age_way;

  resolve_e         res_kind;
  logic [WAY_W-1:0] fill_way;
  logic [WAY_W-1:0] upd_way;
  logic [AGE_W-1:0] upd_age;
  logic [AGE_W-1:0] cur_age;
  ins_mode_e        ins_mode;

  logic             rsp_valid_d;
  logic             rsp_hit_d;
  logic [WAY_W-1:0] rsp_hit_way_d;
  logic [WAY_W-1:0] rsp_victim_way_d;
  logic             rsp_load;

  llc_age_store #(
    .SETS  (SETS),
    .WAYS  (WAYS),
    .TAG_W (TAG_W),
    .AGE_W (AGE_W)
  ) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set   (acc_set),
    .rd_valid (row_valid),
    .rd_tag   (row_tag),
    .rd_age   (row_age),
    .wr_en    (acc_valid),
    .wr_set   (acc_set),
    .wr_way   (upd_way),
    .wr_fill  (!lk_hit),
    .wr_tag   (acc_tag),
    .wr_age   (upd_age)
  );

  llc_age_match #(
    .WAYS  (WAYS),
    .TAG_W (TAG_W)
  ) match_i (
    .row_valid (row_valid),
    .row_tag   (row_tag),
    .look_tag  (acc_tag),
    .hit       (lk_hit),
    .hit_way   (lk_hit_way),
    .free_any  (lk_free_any),
    .free_way  (lk_free_way)
  );

  llc_age_victim #(
    .WAYS  (WAYS),
    .AGE_W (AGE_W)
  ) victim_i (
    .row_age    (row_age),
    .top_found  (lk_top_found),
    .victim_way (lk_age_way)
  );

  // Decide what the access does and what the single write carries.
  always_comb begin
    ins_mode = ins_mode_e'(acc_ins_mode);
    if (lk_hit) begin
      res_kind = RES_HIT;
    end else if (lk_free_any) begin
      res_kind = RES_FREE;
    end else begin
      res_kind = RES_EVICT;
    end

    fill_way = (res_kind == RES_FREE) ? lk_free_way : lk_age_way;
    upd_way  = (res_kind == RES_HIT) ? lk_hit_way : fill_way;
    cur_age  = row_age[lk_hit_way];

    if (res_kind == RES_HIT) begin
      upd_age = (cur_age == '0) ? cur_age : cur_age - AGE_W'(1);
    end else if (ins_mode == INS_NEAR) begin
      upd_age = AGE_NEAR;
    end else begin
      upd_age = AGE_TOP;
    end
  end

  // Response next state.
  always_comb begin
    rsp_valid_d      = acc_valid;
    rsp_load         = acc_valid;
    rsp_hit_d        = (res_kind == RES_HIT);
    rsp_hit_way_d    = (res_kind == RES_HIT) ? lk_hit_way : '0;
    rsp_victim_way_d = (res_kind == RES_HIT) ? '0 : fill_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit        <= 1'b0;
      rsp_hit_way    <= '0;
      rsp_victim_way <= '0;
    end else if (rsp_load) begin
      rsp_hit        <= rsp_hit_d;
      rsp_hit_way    <= rsp_hit_way_d;
      rsp_victim_way <= rsp_victim_way_d;
    end
  end

endmodule

// File: rtl/llc_age_replacer_chk.sv
module llc_age_replacer_chk #(
  parameter int ADDR_W = 15,
  parameter int WAY_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [WAY_W-1:0]  rsp_hit_way,
  input logic [WAY_W-1:0]  rsp_victim_way
);

  p_strobe_gives_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);

  p_idle_no_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);

  p_repeat_line_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && $past(acc_valid) && (acc_addr == $past(acc_addr))) |=> rsp_hit);

  p_repeat_same_way_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && $past(acc_valid) && (acc_addr == $past(acc_addr)))
      |=> (rsp_hit_way == $past(rsp_hit ? rsp_hit_way : rsp_victim_way)));

  p_known_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$isunknown({rsp_hit, rsp_hit_way, rsp_victim_way}));

endmodule

bind llc_age_replacer llc_age_replacer_chk #(
  .ADDR_W (ADDR_W),
  .WAY_W  (WAY_W)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_valid      (acc_valid),
  .acc_addr       (acc_addr),
  .rsp_valid      (rsp_valid),
  .rsp_hit        (rsp_hit),
  .rsp_hit_way    (rsp_hit_way),
  .rsp_victim_way (rsp_victim_way)
);

// File: tb/llc_age_replacer_tb_top.sv
module llc_age_replacer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int NS = 16;
  localparam int NW = 4;

  logic        clk;
  logic        rst_n;
  logic        acc_valid;
  logic [14:0] acc_addr;
  logic        acc_ins_mode;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [1:0]  rsp_hit_way;
  logic [1:0]  rsp_victim_way;

  int n_chk;
  int n_fail;
  bit done;

  llc_age_replacer dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_valid      (acc_valid),
    .acc_addr       (acc_addr),
    .acc_ins_mode   (acc_ins_mode),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_hit_way    (rsp_hit_way),
    .rsp_victim_way (rsp_victim_way)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [14:0] mk(int s, int t, int o);
    logic [7:0] tt = t[7:0];
    logic [3:0] ss = s[3:0];
    logic [2:0] oo = o[2:0];
    return {tt, ss, oo};
  endfunction

  // Behavioural reference: per-set lists of valid, tag and age.
  int    m_val [NS][NW];
  int    m_tag [NS][NW];
  int    m_age [NS][NW];
  int    e_valid, e_hit, e_hway, e_vway;
  string e_kind;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++)
        for (int w = 0; w < NW; w++) begin
          m_val[s][w] = 0; m_tag[s][w] = 0; m_age[s][w] = 3;
        end
      e_valid = 0; e_hit = 0; e_hway = 0; e_vway = 0; e_kind = "R5";
    end else begin
      e_valid = int'(acc_valid);
      if (acc_valid) begin
        int s;
        int t;
        int hw;
        int vw;
        s  = int'(acc_addr[6:3]);
        t  = int'(acc_addr[14:7]);
        hw = -1;
        for (int w = 0; w < NW; w++)
          if (hw < 0 && m_val[s][w] != 0 && m_tag[s][w] == t) hw = w;
        if (hw >= 0) begin
          e_hit = 1; e_hway = hw; e_vway = 0; e_kind = "R3";
          if (m_age[s][hw] > 0) m_age[s][hw] = m_age[s][hw] - 1;
        end else begin
          vw = -1; e_kind = "R4";
          for (int w = 0; w < NW; w++)
            if (vw < 0 && m_val[s][w] == 0) vw = w;
          if (vw < 0) begin
            e_kind = "R8";
            for (int w = 0; w < NW; w++)
              if (vw < 0 && m_age[s][w] == 3) vw = w;
          end
          if (vw < 0) begin
            int best;
            best = -1; e_kind = "R9";
            for (int w = 0; w < NW; w++)
              if (m_age[s][w] > best) begin best = m_age[s][w]; vw = w; end
          end
          e_hit = 0; e_hway = 0; e_vway = vw;
          m_val[s][vw] = 1; m_tag[s][vw] = t;
          m_age[s][vw] = acc_ins_mode ? 2 : 3;
        end
      end
    end
  end

  // Every-clock comparison, sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 rsp_valid", int'(rsp_valid), e_valid);
      if (e_valid != 0) begin
        chk({e_kind, " rsp_hit"}, int'(rsp_hit), e_hit);
        chk({e_kind, " R11 rsp_hit_way"}, int'(rsp_hit_way), e_hway);
        chk({e_kind, " R11 rsp_victim_way"}, int'(rsp_victim_way), e_vway);
      end
    end
  end

  // One access, then explicit expectations at the next falling edge.
  task automatic acc_chk(int s, int t, int o, int mode, int eh, int ew, int ev, string lbl);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = mk(s, t, o); acc_ins_mode = mode[0];
    @(negedge clk);
    acc_valid = 1'b0;
    chk({lbl, " hit"}, int'(rsp_hit), eh);
    if (eh != 0) chk({lbl, " hit way"}, int'(rsp_hit_way), ew);
    else         chk({lbl, " victim way"}, int'(rsp_victim_way), ev);
  endtask

  task automatic acc(int s, int t, int mode);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = mk(s, t, 0); acc_ins_mode = mode[0];
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      finish_up();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_ins_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 rsp_valid in reset", int'(rsp_valid), 0);
    chk("R5 rsp_hit in reset", int'(rsp_hit), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5, R4, R2: cold set fills from way 0; byte offset ignored.
    acc_chk(2, 5, 0, 0, 0, 0, 0, "R5 first fill");
    acc_chk(2, 5, 7, 0, 1, 0, 0, "R2 offset ignored");
    acc_chk(6, 5, 0, 0, 0, 0, 0, "R2 other set");
    acc_chk(2, 4, 0, 0, 0, 0, 1, "R2 tag bit 7");
    acc_chk(2, 7, 0, 0, 0, 0, 2, "R4 fill way 2");
    acc_chk(2, 8, 0, 0, 0, 0, 3, "R4 fill way 3");
    // ages 2,3,3,3 -> first age-3 way
    acc_chk(2, 9, 0, 0, 0, 0, 1, "R8 oldest way");
    @(negedge clk);
    chk("R1 idle no response", int'(rsp_valid), 0);

    // R6: mode 1 fill in way 0 gives age 2; mode 0 fills give age 3.
    acc(4, 1, 1); acc(4, 2, 0); acc(4, 3, 0); acc(4, 4, 0);
    acc_chk(4, 5, 0, 0, 0, 0, 1, "R6 insertion ages");

    // R9: ages 1,2,2,2 then near-insertion and hit.
    acc(3, 1, 0); acc(3, 2, 0); acc(3, 3, 0); acc(3, 4, 0);
    acc(3, 1, 0); acc(3, 1, 0); acc(3, 2, 0); acc(3, 3, 0); acc(3, 4, 0);
    acc_chk(3, 10, 0, 1, 0, 0, 1, "R9 highest age");
    acc_chk(3, 10, 0, 0, 1, 1, 0, "R3 hit filled line");
    acc_chk(3, 11, 0, 0, 0, 0, 2, "R6 near insertion R9");

    // R7: saturating decrement; ages become 0,1,0,0.
    acc(7, 1, 0); acc(7, 2, 0); acc(7, 3, 0); acc(7, 4, 0);
    for (int i = 0; i < 4; i++) acc(7, 1, 0);
    for (int i = 0; i < 2; i++) acc(7, 2, 0);
    for (int i = 0; i < 3; i++) acc(7, 3, 0);
    for (int i = 0; i < 3; i++) acc(7, 4, 0);
    acc_chk(7, 9, 0, 0, 0, 0, 1, "R7 floor at zero");

    // R10: idle cycles and other sets leave set 8 alone.
    acc(8, 1, 0); acc(8, 2, 0); acc(8, 3, 0); acc(8, 4, 0);
    acc(8, 1, 0);
    for (int i = 0; i < 6; i++) acc(9, 20 + i, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      acc_valid = 1'b0; acc_addr = mk(8, 30 + i, 0); acc_ins_mode = 1'b1;
    end
    acc_chk(8, 2, 0, 0, 1, 1, 0, "R10 line kept");
    acc_chk(8, 21, 0, 0, 0, 0, 2, "R10 neighbours untouched");

    // Back-to-back accesses into one set.
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      acc_valid = 1'b1;
      acc_addr = mk(10, (i % 3 == 2) ? i : 1, i);
      acc_ins_mode = i[0];
    end
    @(negedge clk);
    acc_valid = 1'b0;

    // Mixed traffic on two sets, compared every clock.
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      acc_valid = ($urandom_range(0, 9) < 7);
      acc_addr = mk($urandom_range(0, 1), $urandom_range(0, 6), $urandom_range(0, 7));
      acc_ins_mode = $urandom_range(0, 1) == 1;
    end
    @(negedge clk);
    acc_valid = 1'b0;
    repeat (2) @(negedge clk);
    finish_up();
  end

endmodule